// File: doc/BRIEF.md
# Three-Channel Measurement Conversion Sequencer

This block drives a shared analog-to-digital converter that takes turns measuring battery voltage, battery current and die temperature. A two-bit mode field chooses whether the converter rests, runs one pass, runs a pass at a fixed long interval, or runs passes back to back. For each pass, the sequencer requests the three conversions in a fixed order. It waits for the converter's done strobe after each request, then stores the returned code left-justified in a 16-bit result register.

Each stored result is also checked against a high and a low limit, which sets or clears one alert flag per quantity. Current codes use an offset-binary scale: 0000h is the most negative reading and FFFFh the most positive, so a plain unsigned comparison orders them correctly. Temperature limits are one byte wide and are checked against the upper byte of the temperature result only. The host writes the mode field through a write strobe. The sequencer reads the same field back and clears it by itself when a one-shot pass ends.

Top module: `meas_sequencer`

## Requirements
- R1: After reset the mode field reads 00 (sleep), all three result registers and all three alert flags read 0, and no conversion is requested while the mode stays 00.
- R2: A pass asks for voltage (`conv_sel`=0), then current (1), then temperature (2). Each request is a single-cycle `conv_req` pulse, and the next request comes in the cycle after the previous conversion's `conv_done` is accepted.
- R3: In mode 01 exactly one pass runs, and the mode field reads 00 in the cycle after the temperature result is accepted. No further request follows.
- R4: In mode 11 the next voltage request follows in the cycle after the temperature result is accepted.
- R5: In mode 10 a pass starts at once. After each pass the sequencer idles for TICK_DIV×SCAN_TICKS cycles, and the next voltage request is seen that many cycles after the temperature result is accepted.
- R6: A mode write during a pass does not cut the pass short: all three conversions complete. The new mode takes effect at the end of the pass. A change from 11 to 01 gives one more pass, and a change to 00 stops after the current pass.
- R7: Results are left-justified with zero fill. Voltage is 14 bits (low 2 bits zero), current is 12 bits (low 4 bits zero) and temperature is 11 bits (low 5 bits zero).
- R8: A result register changes only when the done strobe for its own channel is accepted. A `conv_done` that arrives while no conversion is pending has no effect.
- R9: The voltage and current alerts are set after a conversion when the 16-bit result is strictly above the high limit or strictly below the low limit, and cleared otherwise. The comparison is unsigned, which is correct for offset-binary current codes.
- R10: The temperature alert compares only result bits 15:8 against the 8-bit limits, using the same strict rule. Differences in the lower bits never change it.
- R11: A host mode write in the same cycle as the one-shot self-clear takes priority: the written value is kept.
- R12: A mode write during the scan idle interval acts immediately. A non-zero mode other than 10 makes the voltage request appear in the cycle after the write lands, and 00 returns the sequencer to sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Host write strobe for the mode field |
| mode_wr_data | input | 2 | Mode value to write: 00 sleep, 01 one pass, 10 timed scan, 11 continuous |
| mode_field | output | 2 | Current mode field, including the self-clear |
| conv_req | output | 1 | Single-cycle conversion request |
| conv_sel | output | 2 | Channel of the pending conversion: 0 voltage, 1 current, 2 temperature |
| conv_done | input | 1 | Converter strobe: `conv_data` is valid |
| conv_data | input | CONV_W (14) | Right-justified raw code from the converter |
| volt_hi | input | 16 | Voltage high limit |
| volt_lo | input | 16 | Voltage low limit |
| cur_hi | input | 16 | Current high limit, offset-binary |
| cur_lo | input | 16 | Current low limit, offset-binary |
| temp_hi | input | 8 | Temperature high limit, upper byte |
| temp_lo | input | 8 | Temperature low limit, upper byte |
| volt_res | output | 16 | Voltage result |
| cur_res | output | 16 | Current result |
| temp_res | output | 16 | Temperature result |
| volt_alert | output | 1 | Voltage out of limits |
| cur_alert | output | 1 | Current out of limits |
| temp_alert | output | 1 | Temperature out of limits |

## Verification
The hardest cases to reach are the end-of-pass collisions, where a host mode write lands in the same cycle as the final temperature done strobe, or while a pass or a scan idle interval is in progress. The stimulus handles this by playing the converter itself. It holds each done strobe back for a chosen latency and can raise the mode write strobe in the very cycle it returns the temperature code, or partway through the current conversion. Random limits and codes are mixed with codes placed exactly on a limit, and with temperature codes whose upper byte equals a limit while the lower bits do not.

// File: rtl/meas_pkg.sv
package meas_pkg;
   localparam int RES_W = 16;

   typedef enum logic [1:0] {
      MODE_SLEEP = 2'b00,
      MODE_ONE   = 2'b01,
      MODE_SCAN  = 2'b10,
      MODE_CONT  = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      CH_VOLT = 2'd0,
      CH_CUR  = 2'd1,
      CH_TEMP = 2'd2
   } chan_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_WAIT,
      ST_PAUSE
   } seq_state_e;
endpackage

// File: rtl/meas_justify.sv
module meas_justify #(
   parameter int IN_W  = 12,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  raw,
   output logic [OUT_W-1:0] word
);
   initial begin
      assert (IN_W >= 1 && IN_W <= OUT_W)
         else $error("meas_justify: IN_W must lie in 1..OUT_W");
   end

   generate
      if (IN_W == OUT_W) begin : g_full
         assign word = raw;
      end else begin : g_pad
         localparam int PAD_W = OUT_W - IN_W;
         assign word = {raw, {PAD_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/meas_limit_cmp.sv
module meas_limit_cmp #(
   parameter int W = 16
) (
   input  logic [W-1:0] value,
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   output logic         outside
);
   initial begin
      assert (W >= 1) else $error("meas_limit_cmp: W must be positive");
   end

   logic above, below;
   assign above   = value > hi;
   assign below   = value < lo;
   assign outside = above | below;
endmodule

// File: rtl/meas_scan_timer.sv
module meas_scan_timer #(
   parameter int TICK_DIV   = 1000,
   parameter int SCAN_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam int TW = (SCAN_TICKS > 1) ? $clog2(SCAN_TICKS) : 1;
   localparam logic [TW-1:0] TICK_LAST = TW'(SCAN_TICKS - 1);

   initial begin
      assert (TICK_DIV >= 1 && SCAN_TICKS >= 1)
         else $error("meas_scan_timer: divider and tick count must be positive");
   end

   logic tick_last;

   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick_last = run;
      end else begin : g_div
         localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)          pre <= '0;
            else if (pre == PRE_LAST)    pre <= '0;
            else                         pre <= pre + 1'b1;
         end
         assign tick_last = run && (pre == PRE_LAST);
      end
   endgenerate

   logic [TW-1:0] ticks;
   always_ff @(posedge clk) begin
      if (!rst_n || !run)        ticks <= '0;
      else if (tick_last) begin
         if (ticks == TICK_LAST) ticks <= '0;
         else                    ticks <= ticks + 1'b1;
      end
   end

   assign expire = tick_last && (ticks == TICK_LAST);

   AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ticks <= TICK_LAST); // R5
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ticks == '0); // R5
endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer
   import meas_pkg::*;
#(
   parameter int V_BITS     = 14,
   parameter int I_BITS     = 12,
   parameter int T_BITS     = 11,
   parameter int CONV_W     = 14,
   parameter int TEMP_LIM_W = 8,
   parameter int TICK_DIV   = 1000,
   parameter int SCAN_TICKS = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_wr_en,
   input  logic [1:0]            mode_wr_data,
   output logic [1:0]            mode_field,
   output logic                  conv_req,
   output logic [1:0]            conv_sel,
   input  logic                  conv_done,
   input  logic [CONV_W-1:0]     conv_data,
   input  logic [RES_W-1:0]      volt_hi,
   input  logic [RES_W-1:0]      volt_lo,
   input  logic [RES_W-1:0]      cur_hi,
   input  logic [RES_W-1:0]      cur_lo,
   input  logic [TEMP_LIM_W-1:0] temp_hi,
   input  logic [TEMP_LIM_W-1:0] temp_lo,
   output logic [RES_W-1:0]      volt_res,
   output logic [RES_W-1:0]      cur_res,
   output logic [RES_W-1:0]      temp_res,
   output logic                  volt_alert,
   output logic                  cur_alert,
   output logic                  temp_alert
);
   localparam logic [RES_W-1:0] CUR_PAD_MASK  = RES_W'((32'd1 << (RES_W - I_BITS)) - 1);
   localparam logic [RES_W-1:0] TEMP_PAD_MASK = RES_W'((32'd1 << (RES_W - T_BITS)) - 1);
   localparam logic [RES_W-1:0] VOLT_PAD_MASK = RES_W'((32'd1 << (RES_W - V_BITS)) - 1);

   initial begin
      assert (V_BITS <= CONV_W && I_BITS <= CONV_W && T_BITS <= CONV_W)
         else $error("meas_sequencer: converter bus narrower than a channel");
      assert (CONV_W <= RES_W)
         else $error("meas_sequencer: converter bus wider than result");
      assert (TEMP_LIM_W >= 1 && TEMP_LIM_W <= RES_W)
         else $error("meas_sequencer: bad temperature limit width");
   end

   seq_state_e state;
   chan_e      chan;
   mode_e      mode_q;
   mode_e      run_mode;

   logic accept, pass_end, one_done, scan_expire;

   assign accept   = (state == ST_WAIT) && conv_done;
   assign pass_end = accept && (chan == CH_TEMP);
   assign one_done = pass_end && (run_mode == MODE_ONE) && (mode_q == MODE_ONE);

   // mode field: host write has priority over the one-shot self-clear
   always_ff @(posedge clk) begin
      if (!rst_n)          mode_q <= MODE_SLEEP;
      else if (mode_wr_en) mode_q <= mode_e'(mode_wr_data);
      else if (one_done)   mode_q <= MODE_SLEEP;
   end

   meas_scan_timer #(
      .TICK_DIV   (TICK_DIV),
      .SCAN_TICKS (SCAN_TICKS)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == ST_PAUSE),
      .expire (scan_expire)
   );

   // sequencing state machine
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         chan     <= CH_VOLT;
         run_mode <= MODE_SLEEP;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (mode_q != MODE_SLEEP) begin
                  state    <= ST_START;
                  chan     <= CH_VOLT;
                  run_mode <= mode_q;
               end
            end
            ST_START: state <= ST_WAIT;
            ST_WAIT: begin
               if (accept) begin
                  if (chan != CH_TEMP) begin
                     chan  <= (chan == CH_VOLT) ? CH_CUR : CH_TEMP;
                     state <= ST_START;
                  end else if (one_done || mode_q == MODE_SLEEP) begin
                     state <= ST_IDLE;
                  end else if (mode_q == MODE_SCAN) begin
                     state <= ST_PAUSE;
                  end else begin
                     state    <= ST_START;
                     chan     <= CH_VOLT;
                     run_mode <= mode_q;
                  end
               end
            end
            ST_PAUSE: begin
               if (mode_q == MODE_SLEEP) begin
                  state <= ST_IDLE;
               end else if (mode_q != MODE_SCAN || scan_expire) begin
                  state    <= ST_START;
                  chan     <= CH_VOLT;
                  run_mode <= mode_q;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign conv_req   = (state == ST_START);
   assign conv_sel   = chan;
   assign mode_field = mode_q;

   // justification of raw codes
   logic [RES_W-1:0] volt_word, cur_word, temp_word;

   meas_justify #(.IN_W(V_BITS), .OUT_W(RES_W)) u_just_v (
      .raw (conv_data[V_BITS-1:0]), .word (volt_word));
   meas_justify #(.IN_W(I_BITS), .OUT_W(RES_W)) u_just_i (
      .raw (conv_data[I_BITS-1:0]), .word (cur_word));
   meas_justify #(.IN_W(T_BITS), .OUT_W(RES_W)) u_just_t (
      .raw (conv_data[T_BITS-1:0]), .word (temp_word));

   // limit comparison
   logic v_out, i_out, t_out;

   meas_limit_cmp #(.W(RES_W)) u_cmp_v (
      .value (volt_word), .hi (volt_hi), .lo (volt_lo), .outside (v_out));
   meas_limit_cmp #(.W(RES_W)) u_cmp_i (
      .value (cur_word), .hi (cur_hi), .lo (cur_lo), .outside (i_out));
   meas_limit_cmp #(.W(TEMP_LIM_W)) u_cmp_t (
      .value (temp_word[RES_W-1 -: TEMP_LIM_W]), .hi (temp_hi), .lo (temp_lo),
      .outside (t_out));

   // result and alert registers, each written whole on its done strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         volt_res   <= '0;
         cur_res    <= '0;
         temp_res   <= '0;
         volt_alert <= 1'b0;
         cur_alert  <= 1'b0;
         temp_alert <= 1'b0;
      end else if (accept) begin
         unique case (chan)
            CH_VOLT: begin volt_res <= volt_word; volt_alert <= v_out; end
            CH_CUR:  begin cur_res  <= cur_word;  cur_alert  <= i_out; end
            CH_TEMP: begin temp_res <= temp_word; temp_alert <= t_out; end
            default: ;
         endcase
      end
   end

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req); // R2
   AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && conv_sel == CH_CUR) |-> ($past(accept) && $past(conv_sel) == CH_VOLT)); // R2
   AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_end && run_mode == MODE_ONE && mode_q == MODE_ONE && !mode_wr_en)
      |=> (mode_field == MODE_SLEEP && !conv_req)); // R3
   AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_end && mode_q == MODE_CONT && !mode_wr_en) |=> (conv_req && conv_sel == CH_VOLT)); // R4
   AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr_en |=> mode_field == $past(mode_wr_data)); // R11
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_res & CUR_PAD_MASK) == '0) && ((temp_res & TEMP_PAD_MASK) == '0)
      && ((volt_res & VOLT_PAD_MASK) == '0)); // R7
   AST_VOLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && chan == CH_VOLT) |=> $stable(volt_res)); // R8
   AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && chan == CH_TEMP) |=> $stable(temp_res) && $stable(temp_alert)); // R8
endmodule

// File: tb/sim_meas_sequencer.sv
`timescale 1ns/1ps
module sim_meas_sequencer;
   localparam int TD     = 4;
   localparam int STK    = 5;
   localparam int NPAUSE = TD * STK;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr_en = 1'b0;
   logic [1:0]  mode_wr_data = 2'b00;
   logic [1:0]  mode_field;
   logic        conv_req;
   logic [1:0]  conv_sel;
   logic        conv_done = 1'b0;
   logic [13:0] conv_data = '0;
   logic [15:0] volt_hi = 16'hFFFF, volt_lo = 16'h0000;
   logic [15:0] cur_hi  = 16'hFFFF, cur_lo  = 16'h0000;
   logic [7:0]  temp_hi = 8'hFF,    temp_lo = 8'h00;
   logic [15:0] volt_res, cur_res, temp_res;
   logic        volt_alert, cur_alert, temp_alert;

   always #2.5 clk = ~clk;

   meas_sequencer #(.TICK_DIV(TD), .SCAN_TICKS(STK)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
      .mode_field(mode_field), .conv_req(conv_req), .conv_sel(conv_sel),
      .conv_done(conv_done), .conv_data(conv_data),
      .volt_hi(volt_hi), .volt_lo(volt_lo), .cur_hi(cur_hi), .cur_lo(cur_lo),
      .temp_hi(temp_hi), .temp_lo(temp_lo),
      .volt_res(volt_res), .cur_res(cur_res), .temp_res(temp_res),
      .volt_alert(volt_alert), .cur_alert(cur_alert), .temp_alert(temp_alert));

   int vectors = 0;
   int misses  = 0;
   logic [15:0] e_v = '0, e_i = '0, e_t = '0;
   logic        ea_v = 1'b0, ea_i = 1'b0, ea_t = 1'b0;

   function automatic logic [15:0] justify(input logic [13:0] raw, input int bits);
      logic [15:0] m;
      m = 16'((32'd1 << bits) - 1);
      return 16'((32'(raw) & 32'(m)) << (16 - bits));
   endfunction

   function automatic logic outside16(input logic [15:0] v, hi, lo);
      return (v > hi) || (v < lo);
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] act, exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_outputs(input string tag);
      chk("R7 R8", {tag, " volt_res"}, volt_res, e_v);
      chk("R7 R8", {tag, " cur_res"},  cur_res,  e_i);
      chk("R7 R8", {tag, " temp_res"}, temp_res, e_t);
      chk("R9",  {tag, " volt_alert"}, 16'(volt_alert), 16'(ea_v));
      chk("R9",  {tag, " cur_alert"},  16'(cur_alert),  16'(ea_i));
      chk("R10", {tag, " temp_alert"}, 16'(temp_alert), 16'(ea_t));
   endtask

   task automatic wait_req(output int n, input int limit);
      n = 0;
      while (!conv_req && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic write_mode(input logic [1:0] m);
      mode_wr_en = 1'b1; mode_wr_data = m;
      @(negedge clk);
      mode_wr_en = 1'b0;
   endtask

   task automatic finish_conv(input int sel, input logic [13:0] raw, input int lat,
                              input bit wr, input logic [1:0] wd);
      repeat (lat) @(negedge clk);
      conv_data = raw; conv_done = 1'b1;
      if (wr) begin mode_wr_en = 1'b1; mode_wr_data = wd; end
      @(negedge clk);
      conv_done = 1'b0; mode_wr_en = 1'b0; conv_data = 14'($urandom);
      case (sel)
         0: begin e_v = justify(raw, 14); ea_v = outside16(e_v, volt_hi, volt_lo); end
         1: begin e_i = justify(raw, 12); ea_i = outside16(e_i, cur_hi, cur_lo); end
         default: begin
            e_t = justify(raw, 11);
            ea_t = (e_t[15:8] > temp_hi) || (e_t[15:8] < temp_lo);
         end
      endcase
      chk_outputs("conv");
   endtask

   task automatic run_conv(input int sel, input logic [13:0] raw, input int lat,
                           input bit wr, input logic [1:0] wd);
      int n;
      wait_req(n, 300);
      chk("R2", "request present", 16'(conv_req), 16'd1);
      chk("R2", "channel order", 16'(conv_sel), 16'(sel));
      finish_conv(sel, raw, lat, wr, wd);
   endtask

   task automatic run_pass(input logic [13:0] rv, ri, rt);
      run_conv(0, rv, 1 + int'($urandom % 4), 1'b0, 2'b00);
      run_conv(1, ri, 1 + int'($urandom % 4), 1'b0, 2'b00);
      run_conv(2, rt, 1 + int'($urandom % 4), 1'b0, 2'b00);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state and sleep
      chk("R1", "mode after reset", 16'(mode_field), 16'd0);
      chk("R1", "no request", 16'(conv_req), 16'd0);
      chk_outputs("reset R1");
      wait_req(n, 12);
      chk("R1", "sleep stays quiet", 16'(n), 16'd12);

      // R8: stray done while nothing pending
      conv_data = 14'h3FFF; conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      @(negedge clk);
      chk_outputs("stray done R8");

      // R3: directed single pass
      write_mode(2'b01);
      run_pass(14'h2C07, 14'h0ABC, 14'h05A3);
      chk("R3", "mode cleared", 16'(mode_field), 16'd0);
      wait_req(n, 15);
      chk("R3", "no further pass", 16'(n), 16'd15);

      // R9/R10: limit boundaries (strict comparison, temperature upper byte)
      volt_hi = justify(14'h1000, 14);
      cur_lo  = justify(14'h0800, 12);
      temp_hi = 8'h80; temp_lo = 8'h10;
      write_mode(2'b01);
      run_pass(14'h1000, 14'h0800, 14'h0407);
      chk("R9", "volt equal hi", 16'(volt_alert), 16'd0);
      chk("R9", "cur equal lo", 16'(cur_alert), 16'd0);
      chk("R10", "temp low bits ignored", 16'(temp_alert), 16'd0);
      write_mode(2'b01);
      run_pass(14'h1001, 14'h07FF, 14'h0408);
      chk("R9", "volt above hi", 16'(volt_alert), 16'd1);
      chk("R9", "cur below lo", 16'(cur_alert), 16'd1);
      chk("R10", "temp above hi", 16'(temp_alert), 16'd1);

      // random single passes with random limits
      for (int k = 0; k < 24; k++) begin
         volt_hi = 16'($urandom); volt_lo = 16'($urandom) >> 1;
         cur_hi  = 16'($urandom) | 16'h4000; cur_lo = 16'($urandom) >> 1;
         temp_hi = 8'($urandom); temp_lo = 8'($urandom) >> 1;
         write_mode(2'b01);
         run_pass(14'($urandom), 14'($urandom) & 14'h0FFF, 14'($urandom) & 14'h07FF);
         chk("R3", "random pass clears mode", 16'(mode_field), 16'd0);
      end

      // R4 and R6: continuous mode and mid-pass changes
      write_mode(2'b11);
      run_pass(14'($urandom), 14'($urandom), 14'($urandom));
      wait_req(n, 10);
      chk("R4", "back-to-back request", 16'(n), 16'd0);
      run_conv(0, 14'($urandom), 2, 1'b0, 2'b00);
      wait_req(n, 10);
      write_mode(2'b01);
      finish_conv(1, 14'($urandom), 2, 1'b0, 2'b00);
      run_conv(2, 14'($urandom), 2, 1'b0, 2'b00);
      chk("R6", "one-shot kept after cont pass", 16'(mode_field), 16'd1);
      wait_req(n, 10);
      chk("R6", "one more pass starts", 16'(n), 16'd0);
      run_conv(0, 14'($urandom), 1, 1'b0, 2'b00);
      wait_req(n, 10);
      write_mode(2'b00);
      finish_conv(1, 14'($urandom), 1, 1'b0, 2'b00);
      run_conv(2, 14'($urandom), 1, 1'b0, 2'b00);
      wait_req(n, 15);
      chk("R6", "sleep after finished pass", 16'(n), 16'd15);

      // R5: scan interval
      write_mode(2'b10);
      run_pass(14'($urandom), 14'($urandom), 14'($urandom));
      wait_req(n, 200);
      chk("R5", "scan idle cycles", 16'(n), 16'(NPAUSE));
      run_pass(14'($urandom), 14'($urandom), 14'($urandom));
      wait_req(n, 200);
      chk("R5", "second scan idle cycles", 16'(n), 16'(NPAUSE));
      run_pass(14'($urandom), 14'($urandom), 14'($urandom));

      // R12: mode change inside the scan idle interval
      repeat (5) @(negedge clk);
      write_mode(2'b11);
      wait_req(n, 50);
      chk("R12", "request right after write", 16'(n), 16'd1);
      run_conv(0, 14'($urandom), 1, 1'b0, 2'b00);
      wait_req(n, 10);
      write_mode(2'b10);
      finish_conv(1, 14'($urandom), 1, 1'b0, 2'b00);
      run_conv(2, 14'($urandom), 1, 1'b0, 2'b00);
      repeat (3) @(negedge clk);
      write_mode(2'b00);
      wait_req(n, 40);
      chk("R12", "sleep from idle interval", 16'(n), 16'd40);

      // R11: host write collides with one-shot self-clear
      write_mode(2'b01);
      run_conv(0, 14'($urandom), 1, 1'b0, 2'b00);
      run_conv(1, 14'($urandom), 1, 1'b0, 2'b00);
      run_conv(2, 14'($urandom), 1, 1'b1, 2'b11);
      chk("R11", "host value kept", 16'(mode_field), 16'd3);
      wait_req(n, 10);
      chk("R11", "continuous follows", 16'(n), 16'd1);
      run_conv(0, 14'($urandom), 1, 1'b1, 2'b00);
      run_conv(1, 14'($urandom), 1, 1'b0, 2'b00);
      run_conv(2, 14'($urandom), 1, 1'b0, 2'b00);
      wait_req(n, 15);
      chk("R6", "stopped after last pass", 16'(n), 16'd15);

      finish_run();
   end
endmodule